// File: doc/BRIEF.md
# Tapped Serial Delay Line

This block is a bit-serial delay line built from cells of sixteen stages each. On every clock edge where the shift enable is high, the serial input enters the first stage and every stored bit moves one stage further along. A live tap address picks which stage drives the output, so the delay through the line can be changed at any moment, between clock edges, without disturbing the stored bits.

The cells are chained: the last stage of each cell feeds the first stage of the next, and the last stage of the final cell is always visible on a dedicated cascade pin. A longer line can therefore be built by wiring that pin into the serial input of another instance. Within one instance, the high address bits pick the cell and the low four bits pick the stage inside it. The stored bits have no reset. Every stage starts at a value set by a parameter and then holds only what has been shifted in.

Top module: `tapsr_line`

## Requirements
- R1: The line holds 16*UNITS stages (64 by default). Tap address a selects stage a, so the output shows the serial input bit taken on the enabled edge a+1 enabled edges back. The delay therefore runs from 1 to 16*UNITS enabled edges.
- R2: With tap address 0, after an enabled edge the output equals the serial input value present at that edge.
- R3: On an edge with shift enable low, no stage changes. The output for any address, and the cascade pin, keep their values whatever the serial input does.
- R4: The output follows the tap address combinationally. Changing the address between clock edges changes the output at once to the selected stage.
- R5: The cascade pin always shows the last stage of the last cell. It equals the output at the highest address, and after an enabled edge it shows the bit that was in the stage one below.
- R6: The address splits as {cell index, stage in cell}, with the low 4 bits selecting the stage. The last stage of cell u feeds the first stage of cell u+1, so a bit shown at address 15 is shown at address 16 after one enabled edge.
- R7: From time zero every stage holds the parameter INIT_VAL (0 by default) until shifting replaces it.
- R8: A single 1 shifted into an all-zero line appears at the highest address and on the cascade pin after exactly 16*UNITS enabled edges, and leaves on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages shift on its rising edge |
| shift_en | input | 1 | Shift enable; high lets the line advance one stage |
| ser_in | input | 1 | Serial data into the first stage |
| tap_addr | input | ADDR_W (6 by default) | Stage selected for the output; high bits pick the cell |
| tap_out | output | 1 | Bit held in the addressed stage |
| casc_out | output | 1 | Bit held in the last stage of the line, for chaining |

## Verification
The hardest situation to reach from the ports is a bit that travels through every cell boundary and out of the last stage, because it needs a known line content and exactly 16*UNITS enabled edges with gaps in between. The bench first flushes the line with zeros, injects one marked bit and clocks it down with the address fixed at the top stage, so its arrival edge and its departure edge can each be checked. Address changes inside a single low clock phase reach the combinational selection path without any edge. Disabled edges with a toggling serial input show that nothing moves.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
    localparam int CELL_DEPTH = 16;
    localparam int TAP_W      = $clog2(CELL_DEPTH);

    typedef struct packed {
        logic [CELL_DEPTH-1:0] stg;
    } cell_state_t;
endpackage

// File: rtl/tapsr_cell.sv
module tapsr_cell
    import tapsr_pkg::*;
#(
    parameter logic INIT_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             din,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             tap_bit,
    output logic             casc_bit
);
    cell_state_t st_d;
    cell_state_t st_q = '{stg: {CELL_DEPTH{INIT_VAL}}};

    // next contents: advance one stage only when enabled
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.stg = {st_q.stg[CELL_DEPTH-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // live tap selection, no register on the path
    assign tap_bit  = st_q.stg[tap_sel];
    assign casc_bit = st_q.stg[CELL_DEPTH-1];
endmodule

// File: rtl/tapsr_unit_sel.sv
module tapsr_unit_sel #(
    parameter int UNITS  = 4,
    parameter int UNIT_W = 2
) (
    input  logic [UNITS-1:0]  taps,
    input  logic [UNIT_W-1:0] unit_idx,
    output logic              pick
);
    // an index past the last cell yields 0
    always_comb begin
        pick = 1'b0;
        for (int u = 0; u < UNITS; u++) begin
            if (unit_idx == UNIT_W'(u)) begin
                pick = taps[u];
            end
        end
    end
endmodule

// File: rtl/tapsr_line.sv
module tapsr_line
    import tapsr_pkg::*;
#(
    parameter int   UNITS    = 4,
    parameter logic INIT_VAL = 1'b0,
    localparam int  UIDX_W   = (UNITS > 1) ? $clog2(UNITS) : 0,
    localparam int  ADDR_W   = TAP_W + UIDX_W
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic [ADDR_W-1:0] tap_addr,
    output logic              tap_out,
    output logic              casc_out
);
    localparam int UNIT_W = (UNITS > 1) ? UIDX_W : 1;
    localparam int TOTAL  = CELL_DEPTH * UNITS;

    logic [UNITS:0]     link;
    logic [UNITS-1:0]   taps;
    logic [UNIT_W-1:0]  unit_idx;
    logic [TAP_W-1:0]   stage_idx;

    assign link[0]   = ser_in;
    assign stage_idx = tap_addr[TAP_W-1:0];

    generate
        if (UNITS > 1) begin : g_multi
            assign unit_idx = tap_addr[ADDR_W-1:TAP_W];
        end else begin : g_single
            assign unit_idx = '0;
        end
    endgenerate

    generate
        for (genvar u = 0; u < UNITS; u++) begin : g_cell
            tapsr_cell #(
                .INIT_VAL (INIT_VAL)
            ) u_cell (
                .clk      (clk),
                .shift_en (shift_en),
                .din      (link[u]),
                .tap_sel  (stage_idx),
                .tap_bit  (taps[u]),
                .casc_bit (link[u+1])
            );
        end
    endgenerate

    tapsr_unit_sel #(
        .UNITS  (UNITS),
        .UNIT_W (UNIT_W)
    ) u_sel (
        .taps     (taps),
        .unit_idx (unit_idx),
        .pick     (tap_out)
    );

    assign casc_out = link[UNITS];
endmodule

// File: rtl/tapsr_line_chk.sv
module tapsr_line_chk #(
    parameter int ADDR_W = 6,
    parameter int LAST   = 63
) (
    input logic              clk,
    input logic              shift_en,
    input logic              ser_in,
    input logic [ADDR_W-1:0] tap_addr,
    input logic              tap_out,
    input logic              casc_out
);
    // no reset exists: checks start after the first edge
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    p_addr0_delay_r2: assert property (@(posedge clk) disable iff (!armed)
        shift_en |=> (tap_addr != '0 || tap_out == $past(ser_in)));

    p_hold_casc_r3: assert property (@(posedge clk) disable iff (!armed)
        !shift_en |=> $stable(casc_out));

    p_hold_tap_r3: assert property (@(posedge clk) disable iff (!armed)
        !shift_en |=> (!$stable(tap_addr) || $stable(tap_out)));

    p_casc_top_r5: assert property (@(posedge clk) disable iff (!armed)
        (int'(tap_addr) == LAST) |-> (tap_out == casc_out));

    p_casc_shift_r5: assert property (@(posedge clk) disable iff (!armed)
        (shift_en && int'(tap_addr) == LAST - 1) |=> (casc_out == $past(tap_out)));

    p_cell_link_r6: assert property (@(posedge clk) disable iff (!armed)
        (shift_en && int'(tap_addr) == 15) |=> (int'(tap_addr) != 16 || tap_out == $past(tap_out)));
endmodule

bind tapsr_line tapsr_line_chk #(
    .ADDR_W (ADDR_W),
    .LAST   (TOTAL - 1)
) u_chk (
    .clk      (clk),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .tap_addr (tap_addr),
    .tap_out  (tap_out),
    .casc_out (casc_out)
);

// File: tb/tapsr_line_test.sv
`timescale 1ns/1ps
module tapsr_line_test;
    localparam int A_W   = 6;
    localparam int TOTAL = 64;
    localparam int LAST  = TOTAL - 1;
    localparam int NVEC  = 20;

    // each entry: {shift_en, ser_in, tap_addr}
    localparam logic [A_W+1:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 6'd0},  {1'b1, 1'b0, 6'd0},  {1'b1, 1'b1, 6'd1},
        {1'b1, 1'b1, 6'd2},  {1'b0, 1'b0, 6'd0},  {1'b0, 1'b1, 6'd2},
        {1'b1, 1'b0, 6'd3},  {1'b1, 1'b1, 6'd15}, {1'b1, 1'b0, 6'd16},
        {1'b1, 1'b1, 6'd17}, {1'b1, 1'b1, 6'd31}, {1'b1, 1'b0, 6'd32},
        {1'b1, 1'b1, 6'd47}, {1'b0, 1'b0, 6'd48}, {1'b1, 1'b0, 6'd62},
        {1'b1, 1'b1, 6'd63}, {1'b1, 1'b1, 6'd5},  {1'b1, 1'b0, 6'd1},
        {1'b1, 1'b1, 6'd0},  {1'b0, 1'b1, 6'd0}
    };

    logic           clk = 1'b0;
    logic           shift_en = 1'b0;
    logic           ser_in = 1'b0;
    logic [A_W-1:0] tap_addr = '0;
    logic           tap_out;
    logic           casc_out;

    int checks = 0;
    int errors = 0;
    logic hist [TOTAL];
    bit done = 0;

    always #5 clk = ~clk;

    tapsr_line uut (
        .clk      (clk),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .tap_addr (tap_addr),
        .tap_out  (tap_out),
        .casc_out (casc_out)
    );

    task automatic check(input string req);
        checks++;
        if (tap_out !== hist[tap_addr]) begin
            errors++;
            $display("FAIL %s tap_out addr=%0d actual=%b expected=%b", req, tap_addr, tap_out, hist[tap_addr]);
        end
        checks++;
        if (casc_out !== hist[LAST]) begin
            errors++;
            $display("FAIL %s casc_out actual=%b expected=%b", req, casc_out, hist[LAST]);
        end
    endtask

    // inputs change in the low phase; model advances after the rising edge
    task automatic cyc(input logic en, input logic din, input logic [A_W-1:0] a, input string req);
        @(negedge clk);
        shift_en = en;
        ser_in   = din;
        tap_addr = a;
        #1;
        check(req);
        @(posedge clk);
        if (en) begin
            for (int i = LAST; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = din;
        end
    endtask

    initial begin
        for (int i = 0; i < TOTAL; i++) hist[i] = 1'b0;

        // R7: every stage starts at INIT_VAL
        #1;
        for (int a = 0; a < TOTAL; a += 7) begin
            tap_addr = A_W'(a);
            #1;
            check("R7");
        end

        // R1 R2 R3 R6: table walk
        for (int v = 0; v < NVEC; v++) begin
            cyc(VEC[v][A_W+1], VEC[v][A_W], VEC[v][A_W-1:0], "R1");
        end
        cyc(1'b0, 1'b0, 6'd0, "R2");

        // R8: flush, inject one marked bit, clock it to the end
        for (int i = 0; i < TOTAL; i++) cyc(1'b1, 1'b0, 6'd0, "R8");
        cyc(1'b1, 1'b1, 6'd63, "R8");
        for (int i = 1; i < TOTAL; i++) begin
            cyc(1'b1, 1'b0, 6'd63, "R8");
            if (i == 3) cyc(1'b0, 1'b1, 6'd63, "R3");
        end
        @(negedge clk);
        shift_en = 1'b1;
        ser_in   = 1'b0;
        #1;
        checks++;
        if (tap_out !== 1'b1 || casc_out !== 1'b1) begin
            errors++;
            $display("FAIL R8 arrival actual=%b/%b expected=1/1", tap_out, casc_out);
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        checks++;
        if (casc_out !== 1'b0) begin
            errors++;
            $display("FAIL R8 departure actual=%b expected=0", casc_out);
        end
        for (int i = LAST; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = 1'b0;

        // fill a mixed pattern, crossing cell boundaries (R6)
        for (int i = 0; i < 40; i++) cyc(1'b1, logic'((i % 3) == 0), A_W'(i + 10), "R6");

        // R4: address sweep inside one low phase, no edge in between
        @(negedge clk);
        shift_en = 1'b0;
        for (int a = 14; a < 18; a++) begin
            tap_addr = A_W'(a);
            #1;
            check("R4");
        end

        // R3: disabled edges with toggling input move nothing
        for (int i = 0; i < 6; i++) cyc(1'b0, logic'(i[0]), 6'd0, "R3");
        @(negedge clk);
        for (int a = 0; a < TOTAL; a++) begin
            tap_addr = A_W'(a);
            #0.05;
            check("R3");
        end

        // R5: top address mirrors cascade pin
        cyc(1'b1, 1'b1, 6'd63, "R5");
        cyc(1'b1, 1'b0, 6'd62, "R5");
        cyc(1'b0, 1'b0, 6'd63, "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule